// File: doc/BRIEF.md
# Register File with Load Scoreboard

This block holds the general-purpose registers of a 32-bit RISC core: thirty-two 32-bit entries, two read ports and one write-back port. Entry 0 is wired to zero. Each read port and the write-back port can also work on a 64-bit value kept in an even/odd pair. The odd entry holds the upper word, which carries the sign and exponent of a double-precision operand. The pair made of entries 0 and 1 is not a legal 64-bit target.

The block uses a scoreboard instead of forwarding. When an instruction issues and its result will arrive late (a load, or a unit that takes several cycles), the destination entry is marked busy. A 64-bit destination marks both entries of its pair. A later issue that reads or writes a busy entry gets a stall. The mark is removed when the write-back for that entry arrives. A write-back is also passed straight to a read port that reads the same entry in the same cycle, and in that cycle it also releases the stall.

Narrow loads are extended on the way in. A byte or halfword becomes a 32-bit word, either by sign extension or by zero filling, as the write-back request selects.

Top module: `rfsb_top`

## Requirements
- R1: Entry 0 always reads as zero on both ports, and a write-back to it changes nothing.
- R2: A wide access (`*_wide`=1) uses the pair whose even index is the given index with bit 0 cleared. Read data is {odd entry, even entry}. A wide write-back stores `wb_data[63:32]` in the odd entry and `wb_data[31:0]` in the even entry. A narrow read returns the entry in bits 31:0, with bits 63:32 zero.
- R3: A wide access to the pair of entries 0 and 1 is illegal. When `iss_valid` is high and an enabled operand names that pair, `iss_illegal` is high. A wide read of that pair returns zero, and a wide write-back to it writes nothing.
- R4: An accepted issue with `iss_rd_en` and `iss_rd_late` marks its destination (both entries when it is wide). A write-back to an entry removes the mark. If a mark is set and removed for the same entry in the same cycle, the entry ends up marked.
- R5: `iss_stall` is high when `iss_valid` is high and an enabled source or destination (either entry of a wide operand) is marked.
- R6: A narrow write-back takes its size from `wb_size` (0 byte, 1 halfword, 2 or 3 word). A byte or halfword is sign-extended when `wb_signed`=1 and zero-filled when `wb_signed`=0.
- R7: A write-back in the same cycle as a read of the same entry shows its value on the read port, and it removes that entry's contribution to the stall in that cycle.
- R8: Entry 0 is never marked. Neither an issue that names it as destination nor a write-back to it sets or clears any mark, so reading it never stalls.
- R9: After reset, all entries read zero and no entry is marked.
- R10: An issue that is stalled or illegal marks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_rs1_en | input | 1 | First source operand is used |
| iss_rs1 | input | 5 | First source index |
| iss_rs1_wide | input | 1 | First source is a 64-bit pair |
| iss_rs2_en | input | 1 | Second source operand is used |
| iss_rs2 | input | 5 | Second source index |
| iss_rs2_wide | input | 1 | Second source is a 64-bit pair |
| iss_rd_en | input | 1 | Instruction has a destination |
| iss_rd | input | 5 | Destination index |
| iss_rd_wide | input | 1 | Destination is a 64-bit pair |
| iss_rd_late | input | 1 | Result arrives later; mark the destination |
| iss_stall | output | 1 | Issue must wait on a marked entry |
| iss_illegal | output | 1 | Issue names the pair of entries 0 and 1 |
| rs1_data | output | 64 | First source read data |
| rs2_data | output | 64 | Second source read data |
| wb_valid | input | 1 | Write-back present |
| wb_rd | input | 5 | Write-back index |
| wb_wide | input | 1 | Write-back is a 64-bit pair |
| wb_size | input | 2 | Narrow size: 0 byte, 1 halfword, 2/3 word |
| wb_signed | input | 1 | Sign-extend a narrow value |
| wb_data | input | 64 | Write-back data |

## Verification
Narrow write-backs use values whose top bit is set and carry unrelated data in their upper bits. This shows the difference between sign extension, zero filling and a truncated copy. Wide write-backs use a different value in each word, so reading either half as a narrow entry shows whether the words landed in the wrong order. Stalls are tested with every way an entry can be named: first source, second source, destination, and the odd half of a wide mark. Write-backs are given in the same cycle as a read and, separately, in the same cycle as a new mark. This separates a correct bypass and set-over-clear priority from a design that waits one cycle or lets the clear win.

// File: rtl/rfsb_pkg.sv
package rfsb_pkg;

   typedef enum logic [1:0] {
      WB_BYTE = 2'd0,
      WB_HALF = 2'd1,
      WB_WORD = 2'd2,
      WB_WORD_ALT = 2'd3
   } wb_size_e;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned HALF_W = 16;

endpackage

// File: rtl/rfsb_target.sv
module rfsb_target #(
   parameter int unsigned NREGS = 32,
   localparam int unsigned AW = $clog2(NREGS)
) (
   input  logic                 en,
   input  logic [AW-1:0]        idx,
   input  logic                 wide,
   output logic [NREGS-1:0]     vec,
   output logic                 illegal
);

   logic [AW-1:0] even_idx;
   logic          pair_zero;

   assign even_idx  = {idx[AW-1:1], 1'b0};
   assign pair_zero = (idx[AW-1:1] == '0);

   always_comb begin
      vec     = '0;
      illegal = 1'b0;
      if (en) begin
         if (wide) begin
            if (pair_zero) begin
               illegal = 1'b1;
            end else begin
               vec[even_idx]          = 1'b1;
               vec[{idx[AW-1:1],1'b1}] = 1'b1;
            end
         end else begin
            vec[idx] = 1'b1;
         end
      end
      vec[0] = 1'b0;
   end

endmodule

// File: rtl/rfsb_extend.sv
module rfsb_extend
   import rfsb_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic [1:0]        size,
   input  logic              sgn,
   input  logic [2*XLEN-1:0] din,
   output logic [XLEN-1:0]   lo,
   output logic [XLEN-1:0]   hi
);

   generate
      if (XLEN < 2*HALF_W) begin : g_bad_xlen
         $error("rfsb_extend: XLEN must be at least 32");
      end
   endgenerate

   logic byte_msb;
   logic half_msb;

   assign byte_msb = sgn & din[BYTE_W-1];
   assign half_msb = sgn & din[HALF_W-1];

   always_comb begin
      hi = '0;
      lo = din[XLEN-1:0];
      if (wide) begin
         hi = din[2*XLEN-1:XLEN];
      end else begin
         case (wb_size_e'(size))
            WB_BYTE: lo = {{(XLEN-BYTE_W){byte_msb}}, din[BYTE_W-1:0]};
            WB_HALF: lo = {{(XLEN-HALF_W){half_msb}}, din[HALF_W-1:0]};
            default: lo = din[XLEN-1:0];
         endcase
      end
   end

   // R6: unsigned narrow values leave nothing above their width
   assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide && !sgn && wb_size_e'(size) == WB_BYTE) |-> (lo[XLEN-1:BYTE_W] == '0));

endmodule

// File: rtl/rfsb_storage.sv
module rfsb_storage #(
   parameter int unsigned NREGS = 32,
   parameter int unsigned XLEN  = 32,
   parameter int unsigned NRD   = 2,
   localparam int unsigned AW   = $clog2(NREGS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NREGS-1:0]                we_vec,
   input  logic                            wr_wide,
   input  logic [XLEN-1:0]                 wr_lo,
   input  logic [XLEN-1:0]                 wr_hi,
   input  logic [NRD-1:0][AW-1:0]          rd_idx,
   input  logic [NRD-1:0]                  rd_wide,
   output logic [NRD-1:0][2*XLEN-1:0]      rd_word
);

   generate
      if ((1 << AW) != NREGS || NREGS < 4) begin : g_bad_depth
         $error("rfsb_storage: NREGS must be a power of two of at least 4");
      end
      if (NRD < 1) begin : g_bad_ports
         $error("rfsb_storage: at least one read port is needed");
      end
   endgenerate

   logic [NREGS-1:0][XLEN-1:0] regs_q;
   logic [NREGS-1:0][XLEN-1:0] wd;

   always_comb begin
      for (int i = 0; i < NREGS; i++) begin
         wd[i] = (wr_wide && (i % 2 == 1)) ? wr_hi : wr_lo;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else begin
         for (int i = 1; i < NREGS; i++) begin
            if (we_vec[i]) regs_q[i] <= wd[i];
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_port
      logic [AW-1:0]     base;
      logic [AW-1:0]     odd;
      logic              bad;
      logic [XLEN-1:0]   lo_v;
      logic [XLEN-1:0]   hi_v;
      logic [2*XLEN-1:0] word_v;

      always_comb begin
         base = rd_wide[p] ? {rd_idx[p][AW-1:1], 1'b0} : rd_idx[p];
         odd  = {rd_idx[p][AW-1:1], 1'b1};
         bad  = rd_wide[p] && (rd_idx[p][AW-1:1] == '0);
         lo_v = we_vec[base] ? wd[base] : regs_q[base];
         hi_v = we_vec[odd]  ? wd[odd]  : regs_q[odd];
         if (bad)             word_v = '0;
         else if (rd_wide[p]) word_v = {hi_v, lo_v};
         else                 word_v = {{XLEN{1'b0}}, lo_v};
      end

      assign rd_word[p] = word_v;

      // R1: entry zero reads as zero on every port
      assert_zero_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (!rd_wide[p] && rd_idx[p] == '0) |-> (rd_word[p] == '0));
   end

endmodule

// File: rtl/rfsb_board.sv
module rfsb_board #(
   parameter int unsigned NREGS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NREGS-1:0] set_vec,
   input  logic [NREGS-1:0] clr_vec,
   input  logic [NREGS-1:0] chk_vec,
   output logic             busy
);

   localparam logic [NREGS-1:0] KEEP_MASK = ~NREGS'(1);

   logic [NREGS-1:0] marks_q;
   logic [NREGS-1:0] marks_d;

   assign marks_d = ((marks_q & ~clr_vec) | set_vec) & KEEP_MASK;
   assign busy    = |(marks_q & ~clr_vec & chk_vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) marks_q <= '0;
      else        marks_q <= marks_d;
   end

   // R4: a requested mark is present in the next cycle
   assert_mark_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((marks_q & $past(set_vec)) == $past(set_vec)));

   // R4: a write-back without a competing mark leaves the entry free
   assert_mark_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & ~set_vec) != '0) |=> ((marks_q & $past(clr_vec & ~set_vec)) == '0));

   // R8: entry zero is never marked
   assert_zero_unmarked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !marks_q[0]);

endmodule

// File: rtl/rfsb_top.sv
module rfsb_top #(
   parameter int unsigned NREGS = 32,
   parameter int unsigned XLEN  = 32,
   localparam int unsigned AW   = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic              iss_rs1_en,
   input  logic [AW-1:0]     iss_rs1,
   input  logic              iss_rs1_wide,
   input  logic              iss_rs2_en,
   input  logic [AW-1:0]     iss_rs2,
   input  logic              iss_rs2_wide,
   input  logic              iss_rd_en,
   input  logic [AW-1:0]     iss_rd,
   input  logic              iss_rd_wide,
   input  logic              iss_rd_late,
   output logic              iss_stall,
   output logic              iss_illegal,
   output logic [2*XLEN-1:0] rs1_data,
   output logic [2*XLEN-1:0] rs2_data,
   input  logic              wb_valid,
   input  logic [AW-1:0]     wb_rd,
   input  logic              wb_wide,
   input  logic [1:0]        wb_size,
   input  logic              wb_signed,
   input  logic [2*XLEN-1:0] wb_data
);

   localparam int unsigned NRD = 2;

   logic [NREGS-1:0] rs1_vec, rs2_vec, rd_vec, wb_vec;
   logic             rs1_bad, rs2_bad, rd_bad, wb_bad;
   logic [NREGS-1:0] set_vec;
   logic [XLEN-1:0]  wr_lo, wr_hi;
   logic [NRD-1:0][AW-1:0]     rd_idx;
   logic [NRD-1:0]             rd_wide;
   logic [NRD-1:0][2*XLEN-1:0] rd_word;
   logic             unused_wb_bad;

   rfsb_target #(.NREGS(NREGS)) u_t_rs1 (
      .en(iss_valid & iss_rs1_en), .idx(iss_rs1), .wide(iss_rs1_wide),
      .vec(rs1_vec), .illegal(rs1_bad));
   rfsb_target #(.NREGS(NREGS)) u_t_rs2 (
      .en(iss_valid & iss_rs2_en), .idx(iss_rs2), .wide(iss_rs2_wide),
      .vec(rs2_vec), .illegal(rs2_bad));
   rfsb_target #(.NREGS(NREGS)) u_t_rd (
      .en(iss_valid & iss_rd_en), .idx(iss_rd), .wide(iss_rd_wide),
      .vec(rd_vec), .illegal(rd_bad));
   rfsb_target #(.NREGS(NREGS)) u_t_wb (
      .en(wb_valid), .idx(wb_rd), .wide(wb_wide),
      .vec(wb_vec), .illegal(wb_bad));

   assign unused_wb_bad = wb_bad;
   assign iss_illegal   = rs1_bad | rs2_bad | rd_bad;
   assign set_vec       = (iss_rd_late && !iss_stall && !iss_illegal) ? rd_vec : '0;

   rfsb_board #(.NREGS(NREGS)) u_board (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec), .clr_vec(wb_vec),
      .chk_vec(rs1_vec | rs2_vec | rd_vec),
      .busy(iss_stall));

   rfsb_extend #(.XLEN(XLEN)) u_extend (
      .clk(clk), .rst_n(rst_n),
      .wide(wb_wide), .size(wb_size), .sgn(wb_signed), .din(wb_data),
      .lo(wr_lo), .hi(wr_hi));

   assign rd_idx  = {iss_rs2, iss_rs1};
   assign rd_wide = {iss_rs2_wide, iss_rs1_wide};

   rfsb_storage #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NRD)) u_storage (
      .clk(clk), .rst_n(rst_n),
      .we_vec(wb_vec), .wr_wide(wb_wide), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .rd_idx(rd_idx), .rd_wide(rd_wide), .rd_word(rd_word));

   assign rs1_data = rd_word[0];
   assign rs2_data = rd_word[1];

   // R3: a wide first source naming the pair of entries 0 and 1 is flagged
   assert_pair_zero_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_rs1_en && iss_rs1_wide && iss_rs1[AW-1:1] == '0) |-> iss_illegal);

endmodule

// File: tb/rfsb_top_tb.sv
module rfsb_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 0, iss_rs1_en = 0, iss_rs1_wide = 0;
   logic        iss_rs2_en = 0, iss_rs2_wide = 0;
   logic        iss_rd_en = 0, iss_rd_wide = 0, iss_rd_late = 0;
   logic [4:0]  iss_rs1 = 0, iss_rs2 = 0, iss_rd = 0;
   logic        iss_stall, iss_illegal;
   logic [63:0] rs1_data, rs2_data;
   logic        wb_valid = 0, wb_wide = 0, wb_signed = 0;
   logic [4:0]  wb_rd = 0;
   logic [1:0]  wb_size = 0;
   logic [63:0] wb_data = 0;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   rfsb_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_rs1_en(iss_rs1_en), .iss_rs1(iss_rs1),
      .iss_rs1_wide(iss_rs1_wide), .iss_rs2_en(iss_rs2_en), .iss_rs2(iss_rs2),
      .iss_rs2_wide(iss_rs2_wide), .iss_rd_en(iss_rd_en), .iss_rd(iss_rd),
      .iss_rd_wide(iss_rd_wide), .iss_rd_late(iss_rd_late),
      .iss_stall(iss_stall), .iss_illegal(iss_illegal),
      .rs1_data(rs1_data), .rs2_data(rs2_data),
      .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_wide(wb_wide), .wb_size(wb_size),
      .wb_signed(wb_signed), .wb_data(wb_data));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      iss_valid = 0; iss_rs1_en = 0; iss_rs1_wide = 0; iss_rs2_en = 0; iss_rs2_wide = 0;
      iss_rd_en = 0; iss_rd_wide = 0; iss_rd_late = 0;
      iss_rs1 = 0; iss_rs2 = 0; iss_rd = 0;
      wb_valid = 0; wb_wide = 0; wb_signed = 0; wb_rd = 0; wb_size = 0; wb_data = 0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic do_wb(input logic [4:0] r, input logic w, input logic [1:0] sz,
                        input logic s, input logic [63:0] d);
      wb_valid = 1; wb_rd = r; wb_wide = w; wb_size = sz; wb_signed = s; wb_data = d;
   endtask

   task automatic rd1(input logic [4:0] r, input logic w);
      iss_valid = 1; iss_rs1_en = 1; iss_rs1 = r; iss_rs1_wide = w;
   endtask

   task automatic mark(input logic [4:0] r, input logic w);
      iss_valid = 1; iss_rd_en = 1; iss_rd = r; iss_rd_wide = w; iss_rd_late = 1;
   endtask

   task automatic t_reset();
      rd1(5'd5, 1'b0); settle();
      check("R9 reset data", rs1_data, 64'h0);
      check("R9 reset stall", {63'h0, iss_stall}, 64'h0);
      idle();
   endtask

   task automatic t_zero();
      do_wb(5'd0, 1'b0, 2'd2, 1'b0, 64'h0000_0000_DEAD_BEEF);
      rd1(5'd0, 1'b0); settle();
      check("R1 zero bypass", rs1_data, 64'h0);
      step();
      rd1(5'd0, 1'b0); settle();
      check("R1 zero after write", rs1_data, 64'h0);
      idle();
   endtask

   task automatic t_extend();
      do_wb(5'd6, 0, 2'd0, 1, 64'hAAAA_AAAA_AAAA_AA80); step();
      do_wb(5'd7, 0, 2'd0, 0, 64'hAAAA_AAAA_AAAA_AA80); step();
      do_wb(5'd8, 0, 2'd1, 1, 64'hAAAA_AAAA_AAAA_8001); step();
      do_wb(5'd9, 0, 2'd1, 0, 64'hAAAA_AAAA_AAAA_8001); step();
      do_wb(5'd5, 0, 2'd2, 1, 64'hAAAA_AAAA_1234_5678); step();
      rd1(5'd6, 0); iss_rs2_en = 1; iss_rs2 = 5'd7; settle();
      check("R6 byte signed", rs1_data, 64'h0000_0000_FFFF_FF80);
      check("R6 byte zero", rs2_data, 64'h0000_0000_0000_0080);
      iss_rs1 = 5'd8; iss_rs2 = 5'd9; settle();
      check("R6 half signed", rs1_data, 64'h0000_0000_FFFF_8001);
      check("R6 half zero", rs2_data, 64'h0000_0000_0000_8001);
      iss_rs1 = 5'd5; settle();
      check("R6 word", rs1_data, 64'h0000_0000_1234_5678);
      idle();
   endtask

   task automatic t_pair();
      do_wb(5'd10, 1, 2'd0, 0, 64'h1111_2222_3333_4444); step();
      rd1(5'd10, 0); iss_rs2_en = 1; iss_rs2 = 5'd11; settle();
      check("R2 even low word", rs1_data, 64'h0000_0000_3333_4444);
      check("R2 odd high word", rs2_data, 64'h0000_0000_1111_2222);
      iss_rs1 = 5'd11; iss_rs1_wide = 1; settle();
      check("R2 wide read odd index", rs1_data, 64'h1111_2222_3333_4444);
      idle();
   endtask

   task automatic t_pair_zero();
      rd1(5'd1, 1); settle();
      check("R3 illegal flag", {63'h0, iss_illegal}, 64'h1);
      check("R3 illegal read zero", rs1_data, 64'h0);
      do_wb(5'd0, 1, 2'd0, 0, 64'h5555_6666_7777_8888); step();
      rd1(5'd1, 0); settle();
      check("R3 wide write to pair zero dropped", rs1_data, 64'h0);
      idle();
      // R10: illegal issue with a late destination marks nothing
      rd1(5'd0, 1); mark(5'd12, 0); settle();
      check("R10 illegal seen", {63'h0, iss_illegal}, 64'h1);
      step();
      rd1(5'd12, 0); settle();
      check("R10 illegal issue left no mark", {63'h0, iss_stall}, 64'h0);
      idle();
   endtask

   task automatic t_score();
      mark(5'd13, 0); settle();
      check("R4 mark issue not stalled", {63'h0, iss_stall}, 64'h0);
      step();
      rd1(5'd13, 0); settle();
      check("R5 stall on rs1", {63'h0, iss_stall}, 64'h1);
      idle(); iss_valid = 1; iss_rs2_en = 1; iss_rs2 = 5'd13; settle();
      check("R5 stall on rs2", {63'h0, iss_stall}, 64'h1);
      idle(); mark(5'd13, 0); iss_rd_late = 0; settle();
      check("R5 stall on destination", {63'h0, iss_stall}, 64'h1);
      idle(); rd1(5'd14, 0); settle();
      check("R5 no stall on free entry", {63'h0, iss_stall}, 64'h0);
      idle();
      rd1(5'd13, 0); do_wb(5'd13, 0, 2'd2, 0, 64'h0000_0000_CAFE_F00D); settle();
      check("R7 stall released by write-back", {63'h0, iss_stall}, 64'h0);
      check("R7 bypass data", rs1_data, 64'h0000_0000_CAFE_F00D);
      step();
      rd1(5'd13, 0); settle();
      check("R4 mark cleared", {63'h0, iss_stall}, 64'h0);
      idle();
   endtask

   task automatic t_wide_mark();
      mark(5'd16, 1); step();
      rd1(5'd17, 0); settle();
      check("R4 wide mark covers odd entry", {63'h0, iss_stall}, 64'h1);
      idle(); rd1(5'd16, 0); settle();
      check("R4 wide mark covers even entry", {63'h0, iss_stall}, 64'h1);
      idle(); do_wb(5'd16, 1, 2'd0, 0, 64'h9999_0000_0000_9999); step();
      rd1(5'd17, 0); settle();
      check("R4 wide write-back clears pair", {63'h0, iss_stall}, 64'h0);
      idle();
   endtask

   task automatic t_stalled_no_mark();
      mark(5'd20, 0); step();
      rd1(5'd20, 0); mark(5'd21, 0); settle();
      check("R10 stalled issue", {63'h0, iss_stall}, 64'h1);
      step();
      rd1(5'd21, 0); settle();
      check("R10 stalled issue left no mark", {63'h0, iss_stall}, 64'h0);
      idle(); do_wb(5'd20, 0, 2'd2, 0, 64'h1); step();
   endtask

   task automatic t_reg0_mark();
      mark(5'd0, 0); settle();
      check("R8 destination zero no stall", {63'h0, iss_stall}, 64'h0);
      step();
      rd1(5'd0, 0); iss_rd_en = 1; iss_rd = 5'd0; settle();
      check("R8 entry zero never marked", {63'h0, iss_stall}, 64'h0);
      idle();
   endtask

   task automatic t_set_over_clear();
      mark(5'd24, 0); step();
      mark(5'd24, 0); do_wb(5'd24, 0, 2'd2, 0, 64'h2); settle();
      check("R4 reissue on clearing cycle not stalled", {63'h0, iss_stall}, 64'h0);
      step();
      rd1(5'd24, 0); settle();
      check("R4 set wins over clear", {63'h0, iss_stall}, 64'h1);
      idle(); do_wb(5'd24, 0, 2'd2, 0, 64'h3); step();
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero();
      t_extend();
      t_pair();
      t_pair_zero();
      t_score();
      t_wide_mark();
      t_stalled_no_mark();
      t_reg0_mark();
      t_set_over_clear();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule